// File: doc/BRIEF.md
# General-Purpose I/O Port with Per-Aspect Alternate-Function Overrides

This block is a general-purpose I/O port whose width is set by a parameter. Each pin has a direction bit, a drive-value bit and a synchronized read path. A global pull-up kill bit sits beside them. Software reaches this state through a small register bus with four word addresses.

Peripherals that share a pin can take over single aspects of it through separate enable/value vector pairs, each one bit wide per pin:

- the pull-up;
- the output-driver enable;
- the driven value;
- a toggle of the drive-value bit;
- the digital-input enable.

An aspect whose enable is low stays under register control.

The pad side presents a driven value, a driver enable, a pull-up request and a raw input. The peripherals also get an unsynchronized copy of the gated input, taken ahead of the port's own synchronizer.

Top module: `altio_port`

## Requirements
- R1: While and directly after reset, the direction, drive-value and pull-up-kill registers are all zero, and the synchronizer holds zero. With no override asserted, every pin is then an undriven input with its pull-up off, and every read address returns zero.
- R2: The register addresses are as follows. A write with `bus_wr` high to address 0 loads the direction register; a 1 bit makes the pin an output. Address 1 loads the drive-value register. Address 3 loads the pull-up kill from `bus_wdata[0]`. A write to address 2 changes nothing. `bus_rdata` combinationally returns: address 0 the direction register, address 1 the drive-value register, address 2 the synchronized pin value, address 3 the kill bit in bit 0 with zeros above it.
- R3: For a pin whose pull-up override enable is low, `pad_pu` is 1 only when its direction bit is 0, its drive-value bit is 1 and the kill bit is 0.
- R4: For a pin whose pull-up override enable is high, `pad_pu` equals that pin's pull-up override value, whatever the registers hold.
- R5: `pad_oe` equals the direction override value where the direction override enable is high, and the direction register bit elsewhere.
- R6: Where `pad_oe` is 1, `pad_out` equals the value override where its enable is high, and the drive-value register bit elsewhere. Where `pad_oe` is 0, `pad_out` is 0.
- R7: At each rising edge where a pin's toggle input is high, that pin's drive-value bit inverts. A register write to address 1 in the same cycle takes precedence, and the register loads the written data.
- R8: A pin's input enable equals its input-enable override value where the override enable is high; elsewhere it is 1 when `sleep_mode` is 0 and 0 when `sleep_mode` is 1. `alt_din` equals `pad_in` AND the input enable, combinationally.
- R9: The pin register at address 2 shows `alt_din` after exactly two rising edges of `clk`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| bus_wr | input | 1 | Register write strobe |
| bus_addr | input | 2 | Register word address |
| bus_wdata | input | W | Write data |
| bus_rdata | output | W | Read data, combinational |
| sleep_mode | input | 1 | Device sleep state, disables inputs by default |
| ovr_pu_en | input | W | Pull-up override enable per pin |
| ovr_pu_val | input | W | Pull-up override value per pin |
| ovr_dir_en | input | W | Driver-enable override enable per pin |
| ovr_dir_val | input | W | Driver-enable override value per pin |
| ovr_out_en | input | W | Driven-value override enable per pin |
| ovr_out_val | input | W | Driven-value override value per pin |
| ovr_tgl | input | W | Drive-value bit toggle request per pin |
| ovr_ie_en | input | W | Input-enable override enable per pin |
| ovr_ie_val | input | W | Input-enable override value per pin |
| pad_in | input | W | Raw pad input |
| pad_out | output | W | Value driven onto the pad |
| pad_oe | output | W | Pad driver enable |
| pad_pu | output | W | Pad pull-up enable |
| alt_din | output | W | Gated, unsynchronized input for peripherals |

## Verification
Pad controls and `alt_din` depend only on the current inputs and the register state. They are therefore checked in the same cycle the stimulus is applied, a moment after the falling edge and before the next rising edge. Register writes and toggles take effect at the next rising edge. The checks that follow that edge compare against a bench model that is updated at that edge. The pin register trails `alt_din` by two rising edges, so the model carries a two-stage pipeline and compares address 2 against the value that entered it two edges earlier.

// File: rtl/altio_pkg.sv
package altio_pkg;

    typedef enum logic [1:0] {
        SEL_DIR  = 2'd0,
        SEL_DATA = 2'd1,
        SEL_PIN  = 2'd2,
        SEL_CFG  = 2'd3
    } reg_sel_e;

    typedef struct packed {
        logic pu_en;
        logic pu_val;
        logic dir_en;
        logic dir_val;
        logic out_en;
        logic out_val;
        logic ie_en;
        logic ie_val;
    } pin_ovr_t;

    typedef struct packed {
        logic drive;
        logic oe;
        logic pu;
        logic din;
    } pin_pad_t;

    function automatic logic plain_pullup(input logic dir, input logic data, input logic kill);
        return ({dir, data, kill} == 3'b010);
    endfunction

endpackage

// File: rtl/altio_regs.sv
module altio_regs
    import altio_pkg::*;
#(
    parameter int W = 8
) (
    input  logic         clk,
    input  logic         rst,
    input  logic         wr,
    input  logic [1:0]   addr,
    input  logic [W-1:0] wdata,
    input  logic [W-1:0] tgl,
    output logic [W-1:0] dir_q,
    output logic [W-1:0] data_q,
    output logic         kill_q
);

    reg_sel_e sel;
    assign sel = reg_sel_e'(addr);

    always_ff @(posedge clk) begin
        if (rst) begin
            dir_q  <= '0;
            data_q <= '0;
            kill_q <= 1'b0;
        end else begin
            if (wr && sel == SEL_DIR)  dir_q  <= wdata;
            if (wr && sel == SEL_CFG)  kill_q <= wdata[0];
            if (wr && sel == SEL_DATA) data_q <= wdata;
            else                       data_q <= data_q ^ tgl;
        end
    end

endmodule

// File: rtl/altio_sync.sv
module altio_sync #(
    parameter int W      = 8,
    parameter int STAGES = 2
) (
    input  logic         clk,
    input  logic         rst,
    input  logic [W-1:0] d,
    output logic [W-1:0] q,
    output logic [W-1:0] first_q
);

    localparam int LAST = STAGES - 1;

    logic [W-1:0] stage [STAGES];

    always_ff @(posedge clk) begin
        if (rst) stage[0] <= '0;
        else     stage[0] <= d;
    end

    for (genvar s = 1; s < STAGES; s++) begin : g_stage
        always_ff @(posedge clk) begin
            if (rst) stage[s] <= '0;
            else     stage[s] <= stage[s-1];
        end
    end

    assign q       = stage[LAST];
    assign first_q = stage[0];

endmodule

// File: rtl/altio_pin_mux.sv
module altio_pin_mux
    import altio_pkg::*;
(
    input  logic     dir,
    input  logic     data,
    input  logic     kill,
    input  logic     sleep_mode,
    input  logic     raw_in,
    input  pin_ovr_t ovr,
    output pin_pad_t pad
);

    logic ie;

    always_comb begin
        pad.oe    = ovr.dir_en ? ovr.dir_val : dir;
        pad.drive = pad.oe & (ovr.out_en ? ovr.out_val : data);
        pad.pu    = ovr.pu_en ? ovr.pu_val : plain_pullup(dir, data, kill);
        ie        = ovr.ie_en ? ovr.ie_val : ~sleep_mode;
        pad.din   = raw_in & ie;
    end

endmodule

// File: rtl/altio_port.sv
module altio_port
    import altio_pkg::*;
#(
    parameter int W          = 8,
    parameter int SYNC_DEPTH = 2
) (
    input  logic         clk,
    input  logic         rst,
    input  logic         bus_wr,
    input  logic [1:0]   bus_addr,
    input  logic [W-1:0] bus_wdata,
    output logic [W-1:0] bus_rdata,
    input  logic         sleep_mode,
    input  logic [W-1:0] ovr_pu_en,
    input  logic [W-1:0] ovr_pu_val,
    input  logic [W-1:0] ovr_dir_en,
    input  logic [W-1:0] ovr_dir_val,
    input  logic [W-1:0] ovr_out_en,
    input  logic [W-1:0] ovr_out_val,
    input  logic [W-1:0] ovr_tgl,
    input  logic [W-1:0] ovr_ie_en,
    input  logic [W-1:0] ovr_ie_val,
    input  logic [W-1:0] pad_in,
    output logic [W-1:0] pad_out,
    output logic [W-1:0] pad_oe,
    output logic [W-1:0] pad_pu,
    output logic [W-1:0] alt_din
);

    logic [W-1:0] dir_q;
    logic [W-1:0] data_q;
    logic         kill_q;
    logic [W-1:0] pin_q;
    logic [W-1:0] pin_first_q;

    altio_regs #(.W(W)) u_regs (
        .clk    (clk),
        .rst    (rst),
        .wr     (bus_wr),
        .addr   (bus_addr),
        .wdata  (bus_wdata),
        .tgl    (ovr_tgl),
        .dir_q  (dir_q),
        .data_q (data_q),
        .kill_q (kill_q)
    );

    for (genvar i = 0; i < W; i++) begin : g_pin
        pin_ovr_t ovr;
        pin_pad_t pad;

        assign ovr = '{pu_en:   ovr_pu_en[i],   pu_val:  ovr_pu_val[i],
                       dir_en:  ovr_dir_en[i],  dir_val: ovr_dir_val[i],
                       out_en:  ovr_out_en[i],  out_val: ovr_out_val[i],
                       ie_en:   ovr_ie_en[i],   ie_val:  ovr_ie_val[i]};

        altio_pin_mux u_mux (
            .dir        (dir_q[i]),
            .data       (data_q[i]),
            .kill       (kill_q),
            .sleep_mode (sleep_mode),
            .raw_in     (pad_in[i]),
            .ovr        (ovr),
            .pad        (pad)
        );

        assign pad_out[i] = pad.drive;
        assign pad_oe[i]  = pad.oe;
        assign pad_pu[i]  = pad.pu;
        assign alt_din[i] = pad.din;
    end

    altio_sync #(.W(W), .STAGES(SYNC_DEPTH)) u_sync (
        .clk     (clk),
        .rst     (rst),
        .d       (alt_din),
        .q       (pin_q),
        .first_q (pin_first_q)
    );

    always_comb begin
        unique case (reg_sel_e'(bus_addr))
            SEL_DIR:  bus_rdata = dir_q;
            SEL_DATA: bus_rdata = data_q;
            SEL_PIN:  bus_rdata = pin_q;
            default:  bus_rdata = {{(W-1){1'b0}}, kill_q};
        endcase
    end

endmodule

// File: rtl/altio_port_chk.sv
module altio_port_chk #(
    parameter int W = 8
) (
    input logic         clk,
    input logic         rst,
    input logic         bus_wr,
    input logic [1:0]   bus_addr,
    input logic [W-1:0] bus_rdata,
    input logic [W-1:0] ovr_pu_en,
    input logic [W-1:0] ovr_pu_val,
    input logic [W-1:0] ovr_dir_en,
    input logic [W-1:0] ovr_dir_val,
    input logic [W-1:0] ovr_tgl,
    input logic [W-1:0] pad_out,
    input logic [W-1:0] pad_oe,
    input logic [W-1:0] pad_pu,
    input logic [W-1:0] alt_din,
    input logic [W-1:0] data_q,
    input logic         kill_q
);

    AST_KILL_PULLUP: assert property (@(posedge clk) disable iff (rst)
        kill_q |-> ((pad_pu & ~ovr_pu_en) == '0)); // R3

    AST_PU_OVERRIDE: assert property (@(posedge clk) disable iff (rst)
        (pad_pu & ovr_pu_en) == (ovr_pu_val & ovr_pu_en)); // R4

    AST_OE_OVERRIDE: assert property (@(posedge clk) disable iff (rst)
        (pad_oe & ovr_dir_en) == (ovr_dir_val & ovr_dir_en)); // R5

    AST_UNDRIVEN_LOW: assert property (@(posedge clk) disable iff (rst)
        (pad_out & ~pad_oe) == '0); // R6

    AST_TOGGLE_FLIP: assert property (@(posedge clk) disable iff (rst)
        !(bus_wr && bus_addr == 2'd1) |=> (data_q == ($past(data_q) ^ $past(ovr_tgl)))); // R7

    AST_PIN_READ_DELAY: assert property (@(posedge clk) disable iff (rst)
        (bus_addr == 2'd2) && !$past(rst) && !$past(rst, 2)
        |-> (bus_rdata == $past(alt_din, 2))); // R9

endmodule

bind altio_port altio_port_chk #(.W(W)) u_chk (
    .clk         (clk),
    .rst         (rst),
    .bus_wr      (bus_wr),
    .bus_addr    (bus_addr),
    .bus_rdata   (bus_rdata),
    .ovr_pu_en   (ovr_pu_en),
    .ovr_pu_val  (ovr_pu_val),
    .ovr_dir_en  (ovr_dir_en),
    .ovr_dir_val (ovr_dir_val),
    .ovr_tgl     (ovr_tgl),
    .pad_out     (pad_out),
    .pad_oe      (pad_oe),
    .pad_pu      (pad_pu),
    .alt_din     (alt_din),
    .data_q      (data_q),
    .kill_q      (kill_q)
);

// File: tb/altio_port_bench.sv
`timescale 1ns/1ps
module altio_port_bench;

    localparam int W = 8;

    logic         clk = 1'b0;
    logic         rst;
    logic         bus_wr;
    logic [1:0]   bus_addr;
    logic [W-1:0] bus_wdata;
    logic [W-1:0] bus_rdata;
    logic         sleep_mode;
    logic [W-1:0] ovr_pu_en, ovr_pu_val, ovr_dir_en, ovr_dir_val;
    logic [W-1:0] ovr_out_en, ovr_out_val, ovr_tgl, ovr_ie_en, ovr_ie_val;
    logic [W-1:0] pad_in, pad_out, pad_oe, pad_pu, alt_din;

    int checks = 0;
    int errors = 0;
    bit done = 0;

    logic [W-1:0] m_dir, m_data, m_s1, m_s2;
    logic         m_kill;

    always #5 clk = ~clk;

    altio_port #(.W(W)) u_altio_port (.*);

    task automatic chk(input string tag, input logic [W-1:0] act, input logic [W-1:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s: actual %h expected %h", tag, act, exp);
        end
    endtask

    function automatic logic [W-1:0] exp_ie();
        return (ovr_ie_en & ovr_ie_val) | (~ovr_ie_en & {W{~sleep_mode}});
    endfunction

    function automatic logic [W-1:0] exp_oe();
        return (ovr_dir_en & ovr_dir_val) | (~ovr_dir_en & m_dir);
    endfunction

    function automatic logic [W-1:0] exp_out();
        return exp_oe() & ((ovr_out_en & ovr_out_val) | (~ovr_out_en & m_data));
    endfunction

    function automatic logic [W-1:0] exp_pu();
        return (ovr_pu_en & ovr_pu_val) | (~ovr_pu_en & ~m_dir & m_data & {W{~m_kill}});
    endfunction

    function automatic logic [W-1:0] exp_rd();
        case (bus_addr)
            2'd0:    return m_dir;
            2'd1:    return m_data;
            2'd2:    return m_s2;
            default: return {{(W-1){1'b0}}, m_kill};
        endcase
    endfunction

    task automatic clear_inputs();
        bus_wr = 0; bus_addr = 0; bus_wdata = 0; sleep_mode = 0;
        ovr_pu_en = 0; ovr_pu_val = 0; ovr_dir_en = 0; ovr_dir_val = 0;
        ovr_out_en = 0; ovr_out_val = 0; ovr_tgl = 0; ovr_ie_en = 0;
        ovr_ie_val = 0; pad_in = 0;
    endtask

    // Inputs are set just after a falling edge; check, then advance one cycle.
    task automatic step();
        #1;
        chk("R5 pad_oe", pad_oe, exp_oe());
        chk("R6 pad_out", pad_out, exp_out());
        chk("R3/R4 pad_pu", pad_pu, exp_pu());
        chk("R8 alt_din", alt_din, pad_in & exp_ie());
        chk("R2/R9 bus_rdata", bus_rdata, exp_rd());
        @(posedge clk);
        m_s2 = m_s1;
        m_s1 = pad_in & exp_ie();
        if (bus_wr && bus_addr == 2'd0) m_dir = bus_wdata;
        if (bus_wr && bus_addr == 2'd3) m_kill = bus_wdata[0];
        if (bus_wr && bus_addr == 2'd1) m_data = bus_wdata;
        else                            m_data = m_data ^ ovr_tgl;
        @(negedge clk);
    endtask

    task automatic wr_reg(input logic [1:0] a, input logic [W-1:0] d);
        clear_inputs();
        bus_wr = 1; bus_addr = a; bus_wdata = d;
        step();
    endtask

    initial begin
        void'($urandom(32'd1234));
        clear_inputs();
        rst = 1;
        m_dir = 0; m_data = 0; m_kill = 0; m_s1 = 0; m_s2 = 0;
        repeat (3) @(posedge clk);
        @(negedge clk);
        // R1: reset state, seen on every read address and on the pads
        for (int a = 0; a < 4; a++) begin
            bus_addr = 2'(a);
            #1 chk("R1 reset rdata", bus_rdata, '0);
        end
        chk("R1 reset pad_oe", pad_oe, '0);
        chk("R1 reset pad_pu", pad_pu, '0);
        rst = 0;
        @(negedge clk);
        bus_addr = 0;
        step();

        // R3: pull-up on for input pins with data 1, then killed
        wr_reg(2'd0, 8'h0F);
        wr_reg(2'd1, 8'hFF);
        clear_inputs(); step();
        chk("R3 pu pattern", pad_pu, 8'hF0);
        wr_reg(2'd3, 8'h01);
        clear_inputs(); step();
        chk("R3 kill", pad_pu, 8'h00);
        wr_reg(2'd3, 8'h00);

        // R2: write to the pin address is ignored
        wr_reg(2'd2, 8'hA5);
        clear_inputs(); bus_addr = 2'd0; step();
        chk("R2 dir unchanged", m_dir, 8'h0F);

        // R7: toggle alone, then toggle together with a write
        clear_inputs(); ovr_tgl = 8'h3C; step();
        clear_inputs(); bus_addr = 2'd1; #1 chk("R7 toggled", bus_rdata, 8'hC3);
        step();
        clear_inputs(); ovr_tgl = 8'hFF; bus_wr = 1; bus_addr = 2'd1; bus_wdata = 8'h5A; step();
        clear_inputs(); bus_addr = 2'd1; #1 chk("R7 write wins", bus_rdata, 8'h5A);
        step();

        // R8/R9: sleep gating and two-edge pin latency
        clear_inputs(); sleep_mode = 1; pad_in = 8'hFF; bus_addr = 2'd2; step();
        step(); step();
        chk("R8 sleep blocks pin", bus_rdata, 8'h00);
        clear_inputs(); pad_in = 8'h96; bus_addr = 2'd2; step(); step();
        #1 chk("R9 pin after two edges", bus_rdata, 8'h96);

        for (int n = 0; n < 3000; n++) begin
            bus_wr      = ($urandom_range(3) == 0);
            bus_addr    = 2'($urandom_range(3));
            bus_wdata   = W'($urandom);
            sleep_mode  = ($urandom_range(4) == 0);
            ovr_pu_en   = W'($urandom) & W'($urandom);
            ovr_pu_val  = W'($urandom);
            ovr_dir_en  = W'($urandom) & W'($urandom);
            ovr_dir_val = W'($urandom);
            ovr_out_en  = W'($urandom) & W'($urandom);
            ovr_out_val = W'($urandom);
            ovr_tgl     = W'($urandom) & W'($urandom) & W'($urandom);
            ovr_ie_en   = W'($urandom) & W'($urandom);
            ovr_ie_val  = W'($urandom);
            pad_in      = W'($urandom);
            step();
        end

        done = 1;
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            checks++;
            errors++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("Simulation finished: %0d checks, %0d errors", checks, errors);
            $finish;
        end
    end

endmodule